// File: doc/BRIEF.md
# Restartable Range Copy Engine

This block copies a run of bytes from one memory region into another region of the same length. Each region is named by its exclusive upper address, and both share one byte count. The source is therefore `[src_hi - count, src_hi)` and the destination is `[dst_hi - count, dst_hi)`. The engine moves one byte at a time and starts at the low end of both regions. Each byte is a read from the source followed by a write to the destination.

The only progress the engine keeps is the remaining count, which it returns on `count_o`. The copy can stop on a read fault, a write fault or an interrupt. Software then reissues the operation with the same two high addresses and the returned count. The copy resumes at the first byte not yet written, so no completed byte is copied again. Behaviour for overlapping regions is simply what the ascending order produces.

Top module: `rce_copy_engine`

## Requirements
- R1: After reset, `busy_o` is 0, `status_o` is 0 (none), `count_o` is 0, and neither `rd_req_o` nor `wr_req_o` is asserted.
- R2: A start with `count_i` equal to 0 issues no memory request. One cycle later `status_o` is 1 (done), `busy_o` is 0 and `count_o` is 0.
- R3: While a copy runs, every read address is `src_hi - remaining` and every write address is `dst_hi - remaining`. Successive bytes therefore go strictly upward, one address at a time.
- R4: Each destination byte equals the source byte at the same offset. Bytes outside the destination range are left untouched.
- R5: `count_o` drops by exactly one when a write is acknowledged without fault, and it changes at no other time while busy.
- R6: A read acknowledged with fault stops the engine. `status_o` becomes 2 (fault), `fault_addr_o` holds the read address, `count_o` is unchanged and no write is issued for that byte.
- R7: A write acknowledged with fault stops the engine. `status_o` becomes 2, `fault_addr_o` holds the write address and `count_o` is unchanged.
- R8: An interrupt is taken only after a byte's write completes and bytes remain. The engine stops with `status_o` equal to 3 (interrupted) and `count_o` equal to the bytes left. A read already acknowledged is always followed by its write.
- R9: Reissuing with the same high addresses and the returned count completes the copy. The destination ends identical to an uninterrupted copy.
- R10: When the last byte is written, the engine stops with `status_o` equal to 1 and `count_o` equal to 0.
- R11: A start pulse while `busy_o` is 1 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Launch pulse, sampled while idle |
| src_hi_i | input | ADDR_W | Exclusive upper address of source range |
| dst_hi_i | input | ADDR_W | Exclusive upper address of destination range |
| count_i | input | CNT_W | Bytes remaining to copy |
| rd_req_o | output | 1 | Read request, held until acknowledged |
| rd_addr_o | output | ADDR_W | Read address |
| rd_ack_i | input | 1 | Read response valid |
| rd_data_i | input | DATA_W | Read data |
| rd_fault_i | input | 1 | Read response carries a fault |
| wr_req_o | output | 1 | Write request, held until acknowledged |
| wr_addr_o | output | ADDR_W | Write address |
| wr_data_o | output | DATA_W | Write data |
| wr_ack_i | input | 1 | Write response valid |
| wr_fault_i | input | 1 | Write response carries a fault |
| irq_i | input | 1 | Interrupt request, taken at byte boundaries |
| busy_o | output | 1 | Copy in progress |
| status_o | output | 2 | 0 none, 1 done, 2 fault, 3 interrupted |
| count_o | output | CNT_W | Bytes remaining (the value to reissue with) |
| fault_addr_o | output | ADDR_W | Address of the faulting access |

## Verification
The bench targets the points where a wrong design would lose or repeat work on a restart.

- **Read fault:** a design that decrements the count on the read would resume one byte too far and leave a hole in the destination.
- **Write fault:** a design that decrements before the write acknowledge would skip the faulting byte when restarted.
- **Interrupt:** the interrupt is held high from launch. A design that stops between a read and its write would leave the count unchanged but a byte unwritten. A design that ignores the interrupt would report done instead of interrupted.
- **Zero count and start while busy:** a zero-count launch must finish at once with no request. A start pulse during a copy that is wrongly accepted would end the copy early with zero-count semantics.

// File: rtl/rce_pkg.sv
package rce_pkg;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_READ  = 2'd1,
        PH_WRITE = 2'd2
    } phase_e;

    typedef enum logic [1:0] {
        ST_NONE  = 2'd0,
        ST_DONE  = 2'd1,
        ST_FAULT = 2'd2,
        ST_INTR  = 2'd3
    } stat_e;

endpackage

// File: rtl/rce_offset.sv
// Current address of a range given its exclusive top and the bytes left.
module rce_offset #(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 16
) (
    input  logic [ADDR_W-1:0] hi_i,
    input  logic [CNT_W-1:0]  left_i,
    output logic [ADDR_W-1:0] addr_o
);
    always_comb begin
        addr_o = hi_i - ADDR_W'(left_i);
    end
endmodule

// File: rtl/rce_count_step.sv
// Decrement of the remaining count and detection of the final byte.
module rce_count_step #(
    parameter int CNT_W = 16
) (
    input  logic [CNT_W-1:0] left_i,
    output logic [CNT_W-1:0] next_o,
    output logic             last_o
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    always_comb begin
        next_o = left_i - ONE;
        last_o = (left_i == ONE);
    end
endmodule

// File: rtl/rce_copy_engine.sv
module rce_copy_engine
    import rce_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] src_hi_i,
    input  logic [ADDR_W-1:0] dst_hi_i,
    input  logic [CNT_W-1:0]  count_i,
    output logic              rd_req_o,
    output logic [ADDR_W-1:0] rd_addr_o,
    input  logic              rd_ack_i,
    input  logic [DATA_W-1:0] rd_data_i,
    input  logic              rd_fault_i,
    output logic              wr_req_o,
    output logic [ADDR_W-1:0] wr_addr_o,
    output logic [DATA_W-1:0] wr_data_o,
    input  logic              wr_ack_i,
    input  logic              wr_fault_i,
    input  logic              irq_i,
    output logic              busy_o,
    output logic [1:0]        status_o,
    output logic [CNT_W-1:0]  count_o,
    output logic [ADDR_W-1:0] fault_addr_o
);

    localparam logic [CNT_W-1:0] CNT_ZERO = '0;

    typedef struct packed {
        phase_e            phase;
        stat_e             status;
        logic [ADDR_W-1:0] src_hi;
        logic [ADDR_W-1:0] dst_hi;
        logic [CNT_W-1:0]  left;
        logic [DATA_W-1:0] data;
        logic [ADDR_W-1:0] fault_addr;
    } eng_t;

    eng_t r_q, r_d;

    logic [ADDR_W-1:0] src_cur, dst_cur;
    logic [CNT_W-1:0]  left_dec;
    logic              left_last;

    rce_offset #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) i_src_off (
        .hi_i   (r_q.src_hi),
        .left_i (r_q.left),
        .addr_o (src_cur)
    );

    rce_offset #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) i_dst_off (
        .hi_i   (r_q.dst_hi),
        .left_i (r_q.left),
        .addr_o (dst_cur)
    );

    rce_count_step #(.CNT_W(CNT_W)) i_step (
        .left_i (r_q.left),
        .next_o (left_dec),
        .last_o (left_last)
    );

    always_comb begin
        r_d = r_q;
        unique case (r_q.phase)
            PH_IDLE: begin
                if (start_i) begin
                    r_d.src_hi = src_hi_i;
                    r_d.dst_hi = dst_hi_i;
                    r_d.left   = count_i;
                    if (count_i == CNT_ZERO) begin
                        r_d.status = ST_DONE;
                    end else begin
                        r_d.status = ST_NONE;
                        r_d.phase  = PH_READ;
                    end
                end
            end
            PH_READ: begin
                if (rd_ack_i) begin
                    if (rd_fault_i) begin
                        r_d.phase      = PH_IDLE;
                        r_d.status     = ST_FAULT;
                        r_d.fault_addr = src_cur;
                    end else begin
                        r_d.data  = rd_data_i;
                        r_d.phase = PH_WRITE;
                    end
                end
            end
            PH_WRITE: begin
                if (wr_ack_i) begin
                    if (wr_fault_i) begin
                        r_d.phase      = PH_IDLE;
                        r_d.status     = ST_FAULT;
                        r_d.fault_addr = dst_cur;
                    end else begin
                        r_d.left = left_dec;
                        if (left_last) begin
                            r_d.phase  = PH_IDLE;
                            r_d.status = ST_DONE;
                        end else if (irq_i) begin
                            r_d.phase  = PH_IDLE;
                            r_d.status = ST_INTR;
                        end else begin
                            r_d.phase = PH_READ;
                        end
                    end
                end
            end
            default: r_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '{phase: PH_IDLE, status: ST_NONE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        rd_req_o     = (r_q.phase == PH_READ);
        rd_addr_o    = src_cur;
        wr_req_o     = (r_q.phase == PH_WRITE);
        wr_addr_o    = dst_cur;
        wr_data_o    = r_q.data;
        busy_o       = (r_q.phase != PH_IDLE);
        status_o     = r_q.status;
        count_o      = r_q.left;
        fault_addr_o = r_q.fault_addr;
    end

    // R2
    zero_count_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i && count_i == CNT_ZERO)
        |=> (!busy_o && status_o == ST_DONE && !rd_req_o && !wr_req_o));

    // R5
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(busy_o) && busy_o)
        |-> (count_o == $past(count_o) || count_o == $past(count_o) - CNT_W'(1)));

    // R3
    write_matches_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_req_o)
        |-> ((r_q.src_hi - $past(rd_addr_o)) == (r_q.dst_hi - wr_addr_o)));

    // R8
    write_follows_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req_o && rd_ack_i && !rd_fault_i) |=> wr_req_o);

    // R6
    read_fault_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req_o && rd_ack_i && rd_fault_i)
        |=> (!busy_o && status_o == ST_FAULT && count_o == $past(count_o)
             && fault_addr_o == $past(rd_addr_o)));

    // R7
    write_fault_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req_o && wr_ack_i && wr_fault_i)
        |=> (!busy_o && status_o == ST_FAULT && count_o == $past(count_o)
             && fault_addr_o == $past(wr_addr_o)));

    // R1
    one_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rd_req_o, wr_req_o}));

endmodule

// File: tb/test_rce_copy_engine.sv
module test_rce_copy_engine;

    localparam int CLK_P  = 10;
    localparam int ADDR_W = 8;
    localparam int CNT_W  = 8;
    localparam int DATA_W = 8;

    typedef struct packed {
        logic [7:0] src_hi;
        logic [7:0] dst_hi;
        logic [7:0] cnt;
    } vec_t;

    localparam int NV = 4;
    localparam vec_t VECS [NV] = '{
        '{8'h10, 8'h90, 8'd1},
        '{8'h40, 8'hC0, 8'd16},
        '{8'h7F, 8'hF0, 8'd7},
        '{8'h30, 8'hA3, 8'd3}
    };

    logic clk = 0;
    logic rst_n = 0;
    logic start_i = 0;
    logic [7:0] src_hi_i = 0, dst_hi_i = 0, count_i = 0;
    logic rd_req_o, wr_req_o, busy_o;
    logic [7:0] rd_addr_o, wr_addr_o, wr_data_o, count_o, fault_addr_o;
    logic [1:0] status_o;
    logic rd_ack_i = 0, rd_fault_i = 0, wr_ack_i = 0, wr_fault_i = 0, irq_i = 0;
    logic [7:0] rd_data_i = 0;

    logic [7:0] mem [256];
    logic       rf_en = 0, wf_en = 0;
    logic [7:0] rf_at = 0, wf_at = 0;
    logic [7:0] exp_rd = 0, exp_wr = 0;
    int         order_err = 0;
    int         wr_seen = 0;
    int         tests = 0, fails = 0;

    always #(CLK_P/2) clk = ~clk;

    rce_copy_engine #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .DATA_W(DATA_W)) i_rce_copy_engine (
        .clk, .rst_n, .start_i, .src_hi_i, .dst_hi_i, .count_i,
        .rd_req_o, .rd_addr_o, .rd_ack_i, .rd_data_i, .rd_fault_i,
        .wr_req_o, .wr_addr_o, .wr_data_o, .wr_ack_i, .wr_fault_i,
        .irq_i, .busy_o, .status_o, .count_o, .fault_addr_o
    );

    // Memory model: answers each request one half-cycle after it appears.
    always @(negedge clk) begin
        if (rd_req_o && !rd_ack_i) begin
            rd_ack_i   <= 1'b1;
            rd_data_i  <= mem[rd_addr_o];
            rd_fault_i <= rf_en && (rd_addr_o == rf_at);
            if (rd_addr_o != exp_rd) order_err++;
            if (!(rf_en && rd_addr_o == rf_at)) exp_rd++;
        end else begin
            rd_ack_i   <= 1'b0;
            rd_fault_i <= 1'b0;
        end
        if (wr_req_o && !wr_ack_i) begin
            wr_ack_i   <= 1'b1;
            wr_fault_i <= wf_en && (wr_addr_o == wf_at);
            if (wr_addr_o != exp_wr) order_err++;
            if (!(wf_en && wr_addr_o == wf_at)) begin
                mem[wr_addr_o] = wr_data_o;
                exp_wr++;
                wr_seen++;
            end
        end else begin
            wr_ack_i   <= 1'b0;
            wr_fault_i <= 1'b0;
        end
    end

    function automatic logic [7:0] pat(input logic [7:0] a);
        return a * 8'd7 + 8'd3;
    endfunction

    task automatic chk(input string req, input logic ok, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic init_mem();
        for (int a = 0; a < 256; a++) mem[a] = (a < 128) ? pat(8'(a)) : 8'h00;
    endtask

    // Launch one operation and wait until the engine goes idle.
    task automatic run(input logic [7:0] s, input logic [7:0] d, input logic [7:0] c,
                       input bit poke);
        @(negedge clk);
        exp_rd = s - c;
        exp_wr = d - c;
        order_err = 0;
        wr_seen = 0;
        src_hi_i = s; dst_hi_i = d; count_i = c; start_i = 1;
        @(negedge clk);
        start_i = 0;
        for (int i = 0; i < 2000 && busy_o; i++) begin
            if (poke && i == 3) begin
                start_i = 1; count_i = 0; src_hi_i = 8'h05; dst_hi_i = 8'h85;
            end else begin
                start_i = 0;
            end
            @(negedge clk);
        end
        start_i = 0;
        chk("run-timeout", !busy_o, busy_o, 0);
    endtask

    // Checks that the destination bytes [d-c, d-c+n) hold the source copy.
    function automatic bit copied(input logic [7:0] s, input logic [7:0] d,
                                  input logic [7:0] c, input int n);
        for (int k = 0; k < n; k++)
            if (mem[8'(d - c + 8'(k))] != pat(8'(s - c + 8'(k)))) return 0;
        return 1;
    endfunction

    initial begin
        #(CLK_P * 150000);
        fails++;
        tests++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        init_mem();
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 busy", busy_o == 0, busy_o, 0);
        chk("R1 status", status_o == 0, status_o, 0);
        chk("R1 req", !rd_req_o && !wr_req_o, {rd_req_o, wr_req_o}, 0);
        chk("R1 count", count_o == 0, count_o, 0);
        rst_n = 1;

        // Vector table: plain copies (R3 R4 R10)
        foreach (VECS[v]) begin
            init_mem();
            run(VECS[v].src_hi, VECS[v].dst_hi, VECS[v].cnt, 0);
            chk("R10 status", status_o == 1, status_o, 1);
            chk("R10 count", count_o == 0, count_o, 0);
            chk("R4 data", copied(VECS[v].src_hi, VECS[v].dst_hi, VECS[v].cnt,
                                  int'(VECS[v].cnt)), 0, 1);
            chk("R4 below", mem[8'(VECS[v].dst_hi - VECS[v].cnt - 8'd1)] == 0,
                mem[8'(VECS[v].dst_hi - VECS[v].cnt - 8'd1)], 0);
            chk("R4 above", mem[VECS[v].dst_hi] == 0, mem[VECS[v].dst_hi], 0);
            chk("R3 order", order_err == 0, order_err, 0);
            chk("R5 writes", wr_seen == int'(VECS[v].cnt), wr_seen, int'(VECS[v].cnt));
        end

        // R2 zero count
        init_mem();
        run(8'h20, 8'hB0, 8'd0, 0);
        chk("R2 status", status_o == 1, status_o, 1);
        chk("R2 no write", wr_seen == 0, wr_seen, 0);
        chk("R2 count", count_o == 0, count_o, 0);

        // R6 read fault at the third byte, then R9 resume
        init_mem();
        rf_en = 1; rf_at = 8'h1C;
        run(8'h20, 8'hB0, 8'd6, 0);
        chk("R6 status", status_o == 2, status_o, 2);
        chk("R6 addr", fault_addr_o == 8'h1C, fault_addr_o, 8'h1C);
        chk("R6 count", count_o == 4, count_o, 4);
        chk("R6 writes", wr_seen == 2, wr_seen, 2);
        chk("R6 hole", mem[8'hAC] == 0, mem[8'hAC], 0);
        rf_en = 0;
        run(8'h20, 8'hB0, count_o, 0);
        chk("R9 read resume", status_o == 1 && copied(8'h20, 8'hB0, 8'd6, 6), status_o, 1);

        // R7 write fault at the fourth byte, then R9 resume
        init_mem();
        wf_en = 1; wf_at = 8'hCD;
        run(8'h50, 8'hD0, 8'd6, 0);
        chk("R7 status", status_o == 2, status_o, 2);
        chk("R7 addr", fault_addr_o == 8'hCD, fault_addr_o, 8'hCD);
        chk("R7 count", count_o == 3, count_o, 3);
        chk("R7 unwritten", mem[8'hCD] == 0, mem[8'hCD], 0);
        wf_en = 0;
        run(8'h50, 8'hD0, count_o, 0);
        chk("R9 write resume", status_o == 1 && copied(8'h50, 8'hD0, 8'd6, 6), status_o, 1);
        chk("R9 order", order_err == 0, order_err, 0);

        // R8 interrupt held from launch: one byte, then stop
        init_mem();
        irq_i = 1;
        run(8'h60, 8'hE8, 8'd5, 0);
        chk("R8 status", status_o == 3, status_o, 3);
        chk("R8 count", count_o == 4, count_o, 4);
        chk("R8 writes", wr_seen == 1, wr_seen, 1);
        chk("R8 first byte", mem[8'hE3] == pat(8'h5B), mem[8'hE3], pat(8'h5B));
        chk("R8 next untouched", mem[8'hE4] == 0, mem[8'hE4], 0);
        irq_i = 0;
        run(8'h60, 8'hE8, count_o, 0);
        chk("R9 irq resume", status_o == 1 && copied(8'h60, 8'hE8, 8'd5, 5), status_o, 1);

        // R11 start pulse while busy is ignored
        init_mem();
        run(8'h70, 8'hF8, 8'd8, 1);
        chk("R11 status", status_o == 1, status_o, 1);
        chk("R11 data", copied(8'h70, 8'hF8, 8'd8, 8), 0, 1);
        chk("R11 writes", wr_seen == 8, wr_seen, 8);
        chk("R11 other", mem[8'h84] == 0, mem[8'h84], 0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule